// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block turns the operand fields of one decoded instruction into the 64-bit effective address of its memory operand. A 3-bit mode picks which terms feed a single adder: a base register value, an index register value shifted left by a 2-bit scale code, a sign-extended 32-bit displacement, and the address of the next sequential instruction. Absolute addressing skips the adder and uses a 64-bit constant field from the instruction. The adder result wraps modulo 2^64.

The same constant field serves as an immediate operand. In immediate mode the value goes to a separate output with its own valid flag, and no address is formed. A request is taken on a rising edge. Its result appears on the registered outputs one cycle later, so a new request can be issued every cycle.

Top module: `scaled_addr_gen`

## Requirements
- R1: Mode codes (3 bits): 0 immediate, 1 absolute, 2 register-indirect, 3 register-plus-offset, 4 next-instruction-relative, 5 base+scaled-index+displacement, 6 and 7 reserved. A request with `reqValid` high and mode 1 to 5 raises `addrValid` on the next cycle. `immValid` stays low for such a request.
- R2: In mode 5 the address is `baseVal + (indexVal << scaleCode) + sext(dispVal)`, so scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R3: In mode 2 the address equals `baseVal`. The index, scale and displacement inputs have no effect on it.
- R4: In mode 3 the address is `baseVal + sext(dispVal)`. The index input has no effect; for example, base 172 and displacement 172 give 344.
- R5: In mode 4 the address is `nextIp + sext(dispVal)`. The base input has no effect.
- R6: In mode 1 the address equals `constField`. The base, index and displacement inputs have no effect.
- R7: In mode 0, `immOut` equals `constField` and `immValid` is high one cycle later, while `addrValid` stays low.
- R8: `dispVal` is a signed 32-bit value, sign-extended from bit 31 before it is added.
- R9: Address sums are taken modulo 2^64, and any carry out of bit 63 is dropped.
- R10: During reset and in the cycle after an idle or reserved-mode request, both `addrValid` and `immValid` are low. During reset, `effAddr` and `immOut` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| baseVal | input | 64 | Base register value |
| indexVal | input | 64 | Index register value |
| scaleCode | input | 2 | Index left-shift amount |
| dispVal | input | 32 | Signed displacement |
| nextIp | input | 64 | Address of the next sequential instruction |
| constField | input | 64 | Absolute address or immediate value |
| effAddr | output | 64 | Registered effective address |
| addrValid | output | 1 | effAddr holds a new address |
| immOut | output | 64 | Registered immediate operand |
| immValid | output | 1 | immOut holds a new immediate |

## Verification
Two effects can fall on one request: a negative displacement and the wrap past bit 63. The bench provokes this in scaled-index and next-instruction-relative requests whose sums cross 2^64, in both directions, and compares the output with a reference sum that it computes in 64-bit arithmetic. The other overlap is an immediate issued in the cycle right after an address request, or the reverse. For these back-to-back cases the bench checks that each result carries only its own valid flag, and that the second request does not change the first result.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    MODE_IMM    = 3'd0,
    MODE_ABS    = 3'd1,
    MODE_REGIND = 3'd2,
    MODE_REGOFF = 3'd3,
    MODE_IPREL  = 3'd4,
    MODE_SIB    = 3'd5
  } agu_mode_e;

  // Strobes from the mode decoder into the adder datapath
  typedef struct packed {
    logic addrReq;
    logic immReq;
    logic useBase;
    logic useIndex;
    logic useDisp;
    logic useIp;
    logic useAbs;
  } agu_strobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  mode,
  output agu_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (reqValid) begin
      case (mode)
        MODE_IMM: strobe.immReq = 1'b1;
        MODE_ABS: begin
          strobe.addrReq = 1'b1;
          strobe.useAbs  = 1'b1;
        end
        MODE_REGIND: begin
          strobe.addrReq = 1'b1;
          strobe.useBase = 1'b1;
        end
        MODE_REGOFF: begin
          strobe.addrReq = 1'b1;
          strobe.useBase = 1'b1;
          strobe.useDisp = 1'b1;
        end
        MODE_IPREL: begin
          strobe.addrReq = 1'b1;
          strobe.useIp   = 1'b1;
          strobe.useDisp = 1'b1;
        end
        MODE_SIB: begin
          strobe.addrReq  = 1'b1;
          strobe.useBase  = 1'b1;
          strobe.useIndex = 1'b1;
          strobe.useDisp  = 1'b1;
        end
        default: strobe = '0;
      endcase
    end
  end

  // R1: absolute mode never mixes with adder terms
  assert_abs_alone_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.useAbs |-> !(strobe.useBase || strobe.useIndex || strobe.useDisp || strobe.useIp));

  // R7: an immediate request never also asks for an address
  assert_imm_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.addrReq, strobe.immReq}));

  // R5: next-instruction term and base term never both selected
  assert_ip_no_base_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.useIp |-> !strobe.useBase);

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  agu_strobe_t        strobe,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [SCALE_W-1:0] scaleCode,
  input  logic [DISP_W-1:0]  dispVal,
  input  logic [ADDR_W-1:0]  nextIp,
  input  logic [ADDR_W-1:0]  constField,
  output logic [ADDR_W-1:0]  effAddr,
  output logic               addrValid,
  output logic [ADDR_W-1:0]  immOut,
  output logic               immValid
);

  localparam int SCALE_N = 1 << SCALE_W;
  localparam int EXT_W   = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] shiftOpt [SCALE_N];
  logic [ADDR_W-1:0] scaledIdx;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] termBase, termIdx, termDisp, termIp;
  logic [ADDR_W-1:0] sumAddr, nextAddr;

  // One fixed shifter per scale code; the code picks among them
  for (genvar g = 0; g < SCALE_N; g++) begin : g_scale
    assign shiftOpt[g] = indexVal << g;
  end

  assign scaledIdx = shiftOpt[scaleCode];
  assign dispExt   = {{EXT_W{dispVal[DISP_W-1]}}, dispVal};

  always_comb begin
    termBase = strobe.useBase  ? baseVal   : '0;
    termIdx  = strobe.useIndex ? scaledIdx : '0;
    termDisp = strobe.useDisp  ? dispExt   : '0;
    termIp   = strobe.useIp    ? nextIp    : '0;
    sumAddr  = termBase + termIdx + termDisp + termIp;
    nextAddr = strobe.useAbs ? constField : sumAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effAddr   <= '0;
      addrValid <= 1'b0;
      immOut    <= '0;
      immValid  <= 1'b0;
    end else begin
      addrValid <= strobe.addrReq;
      immValid  <= strobe.immReq;
      if (strobe.addrReq) effAddr <= nextAddr;
      if (strobe.immReq)  immOut  <= constField;
    end
  end

  // R10: the two result flags never rise together
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({addrValid, immValid}));

  // R7: an immediate result leaves the address register alone
  assert_imm_keeps_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    immValid |-> $stable(effAddr));

endmodule

// File: rtl/scaled_addr_gen.sv
module scaled_addr_gen
  import agu_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2:0]         mode,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [SCALE_W-1:0] scaleCode,
  input  logic [DISP_W-1:0]  dispVal,
  input  logic [ADDR_W-1:0]  nextIp,
  input  logic [ADDR_W-1:0]  constField,
  output logic [ADDR_W-1:0]  effAddr,
  output logic               addrValid,
  output logic [ADDR_W-1:0]  immOut,
  output logic               immValid
);

  localparam int EXT_W = ADDR_W - DISP_W;

  agu_strobe_t strobe;

  agu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .mode     (mode),
    .strobe   (strobe)
  );

  agu_datapath #(
    .ADDR_W  (ADDR_W),
    .DISP_W  (DISP_W),
    .SCALE_W (SCALE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .baseVal    (baseVal),
    .indexVal   (indexVal),
    .scaleCode  (scaleCode),
    .dispVal    (dispVal),
    .nextIp     (nextIp),
    .constField (constField),
    .effAddr    (effAddr),
    .addrValid  (addrValid),
    .immOut     (immOut),
    .immValid   (immValid)
  );

  // R1: memory-mode request yields an address one cycle later
  assert_addr_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode >= 3'd1 && mode <= 3'd5) |=> addrValid);

  // R10: idle or reserved request leaves both flags low
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || mode >= 3'd6) |=> (!addrValid && !immValid));

  // R3: register-indirect returns the base unchanged
  assert_regind_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd2) |=> effAddr == $past(baseVal));

  // R6: absolute mode returns the constant field
  assert_abs_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd1) |=> effAddr == $past(constField));

  // R5: next-instruction-relative sum
  assert_iprel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd4) |=>
      effAddr == $past(nextIp) + {{EXT_W{$past(dispVal[DISP_W-1])}}, $past(dispVal)});

  // R7: immediate passes through with its own flag
  assert_imm_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd0) |=> (immValid && !addrValid && immOut == $past(constField)));

endmodule

// File: tb/scaled_addr_gen_bench.sv
`timescale 1ns/1ps
module scaled_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [2:0]  mode;
  logic [63:0] baseVal, indexVal, nextIp, constField;
  logic [1:0]  scaleCode;
  logic [31:0] dispVal;
  logic [63:0] effAddr, immOut;
  logic        addrValid, immValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          expA;
    logic [63:0] addr;
    bit          expI;
    logic [63:0] imm;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #2 clk = ~clk;

  scaled_addr_gen u_scaled_addr_gen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode),
    .baseVal(baseVal), .indexVal(indexVal), .scaleCode(scaleCode),
    .dispVal(dispVal), .nextIp(nextIp), .constField(constField),
    .effAddr(effAddr), .addrValid(addrValid), .immOut(immOut), .immValid(immValid)
  );

  function automatic logic [63:0] sx(input logic [31:0] d);
    return {{32{d[31]}}, d};
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one request per call, expected result pushed to the scoreboard
  task automatic drive(input string tag, input bit v, input logic [2:0] m,
                       input logic [63:0] b, input logic [63:0] x, input logic [1:0] s,
                       input logic [31:0] d, input logic [63:0] ip, input logic [63:0] c);
    exp_t e;
    @(negedge clk);
    reqValid = v; mode = m; baseVal = b; indexVal = x; scaleCode = s;
    dispVal = d; nextIp = ip; constField = c;
    e.tag = tag; e.expA = 1'b0; e.expI = 1'b0; e.addr = '0; e.imm = '0;
    if (v) begin
      case (m)
        3'd0: begin e.expI = 1'b1; e.imm = c; end
        3'd1: begin e.expA = 1'b1; e.addr = c; end
        3'd2: begin e.expA = 1'b1; e.addr = b; end
        3'd3: begin e.expA = 1'b1; e.addr = b + sx(d); end
        3'd4: begin e.expA = 1'b1; e.addr = ip + sx(d); end
        3'd5: begin e.expA = 1'b1; e.addr = b + x * (64'd1 << s) + sx(d); end
        default: ;
      endcase
    end
    q.push_back(e);
  endtask

  // Monitor: compare just after the edge that registers each request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check64({e.tag, " addrValid"}, {63'd0, addrValid}, {63'd0, e.expA});
        check64({e.tag, " immValid"},  {63'd0, immValid},  {63'd0, e.expI});
        if (e.expA) check64({e.tag, " effAddr"}, effAddr, e.addr);
        if (e.expI) check64({e.tag, " immOut"},  immOut,  e.imm);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b1; mode = 3'd5; baseVal = 64'h1234;
    indexVal = 64'h10; scaleCode = 2'd3; dispVal = 32'h8; nextIp = 64'h100;
    constField = 64'hABCD;
    repeat (3) @(negedge clk);
    // R10: reset state, even with a request pending
    check64("R10 reset addrValid", {63'd0, addrValid}, 64'd0);
    check64("R10 reset immValid",  {63'd0, immValid},  64'd0);
    check64("R10 reset effAddr",   effAddr, 64'd0);
    check64("R10 reset immOut",    immOut,  64'd0);
    reqValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R4: worked example 172 + 172
    drive("R4 regoff 172+172", 1, 3'd3, 64'd172, 64'hFFFF, 2'd3, 32'd172, 64'h0, 64'h0);
    // R3: index, scale, displacement ignored
    drive("R3 regind", 1, 3'd2, 64'h0000_7FFF_0000_1000, 64'h55, 2'd2, 32'hFFFF_FF00, 64'h99, 64'h77);
    // R2: every scale code
    for (int s = 0; s < 4; s++)
      drive($sformatf("R2 sib scale%0d", s), 1, 3'd5, 64'h1000, 64'h23, s[1:0], 32'h10, 64'h0, 64'h0);
    // R8: negative displacement
    drive("R8 sib negdisp", 1, 3'd5, 64'h2000, 64'h4, 2'd1, 32'hFFFF_FFF0, 64'h0, 64'h0);
    drive("R8 regoff min disp", 1, 3'd3, 64'h1_0000_0000, 64'h0, 2'd0, 32'h8000_0000, 64'h0, 64'h0);
    // R5: relative to next instruction; base ignored
    drive("R5 iprel fwd", 1, 3'd4, 64'hDEAD, 64'h0, 2'd0, 32'h40, 64'h0040_1000, 64'h0);
    drive("R5 iprel back", 1, 3'd4, 64'hDEAD, 64'h0, 2'd0, 32'hFFFF_FFFC, 64'h0040_1000, 64'h0);
    // R6: absolute constant; base, index, disp ignored
    drive("R6 abs", 1, 3'd1, 64'h1111, 64'h2222, 2'd3, 32'h3333, 64'h4444, 64'hFEDC_BA98_7654_3210);
    // R9: wrap past bit 63 both ways, combined with sign extension
    drive("R9 sib wrap up", 1, 3'd5, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8, 2'd2, 32'h4, 64'h0, 64'h0);
    drive("R9 iprel wrap down", 1, 3'd4, 64'h0, 64'h0, 2'd0, 32'hFFFF_FF00, 64'h10, 64'h0);
    drive("R9 sib big index", 1, 3'd5, 64'h1, 64'h8000_0000_0000_0001, 2'd1, 32'h0, 64'h0, 64'h0);
    // R7: immediate directly after an address, and back again
    drive("R7 imm after addr", 1, 3'd0, 64'h5, 64'h5, 2'd0, 32'h5, 64'h5, 64'h0BAD_F00D_0000_0001);
    drive("R7 addr after imm", 1, 3'd2, 64'h0000_0000_CAFE_0000, 64'h0, 2'd0, 32'h0, 64'h0, 64'h1);
    drive("R7 imm twice", 1, 3'd0, 64'h0, 64'h0, 2'd0, 32'h0, 64'h0, 64'h1234_5678_9ABC_DEF0);
    // R10 / R1: reserved modes and idle cycles produce no flags
    drive("R10 reserved6", 1, 3'd6, 64'h1, 64'h1, 2'd0, 32'h1, 64'h1, 64'h1);
    drive("R10 reserved7", 1, 3'd7, 64'h1, 64'h1, 2'd0, 32'h1, 64'h1, 64'h1);
    drive("R10 idle", 0, 3'd5, 64'h1, 64'h1, 2'd0, 32'h1, 64'h1, 64'h1);
    // R1: mode 1..5 back to back keep addrValid high each cycle
    for (int m = 1; m < 6; m++)
      drive($sformatf("R1 mode%0d", m), 1, m[2:0], 64'h100, 64'h2, 2'd1, 32'h3, 64'h400, 64'h500);
    drive("R1 drain", 0, 3'd0, 64'h0, 64'h0, 2'd0, 32'h0, 64'h0, 64'h0);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule